// File: doc/BRIEF.md
# Master-Mode Serial Word Transmitter

This block sends 16-bit sample words out of a chip as the master of a three-wire serial link. It creates the serial clock, the frame marker and the data line itself. All of them are registered, cycle-accurate functions of one fabric clock `clk_i`. That clock runs at twice the master conversion clock, so one master-clock period spans two `clk_i` cycles. A word arrives on `sample_i` with a one-cycle `sample_vld_i` strobe. It is held in a holding register and moves into the shift register only at a frame boundary.

Three framing modes are selected by two static controls:
- Mode 1: long frame at full-rate serial clock. A frame has 32 bit slots: 16 data bits and then 16 zero slots.
- Mode 2: long frame at half-rate serial clock. A frame has 16 data slots.
- Mode 3: short frame at full-rate serial clock. A frame has 16 data slots.

A further control picks which serial clock edge launches data. In mode 1 the frame marker can be either a pulse or a square wave.

An external frame-sync input can realign the transmitter once after reset. Later pulses on it do nothing. The data line's output enable compares two level inputs, so two transmitters can share one wire. The sequencer has three states:
- `ST_DATA`: shifting data.
- `ST_PAD`: mode 1 zero slots.
- `ST_SYNC`: held by the external sync.

Its transitions are:
- DATA→DATA: next bit, or the word wraps in modes 2 and 3.
- DATA→PAD: the last data slot ends in mode 1.
- PAD→DATA: the last pad slot ends.
- any→SYNC: the first accepted sync.
- SYNC→DATA: the sync input falls.

Top module: `serial_word_master`

## Requirements
- R1: While reset is high the block sits at the start of a frame: SCO = 1 when launch_fall_i = 0, SDO = 0, FSO = 1 when fso_square_i = 0, and the holding and shift registers are cleared.
- R2: Mode 1 (long_frame_i = 1, half_sco_i = 0) uses a 64-cycle frame of 32 slots of 2 cycles each. Slots 0..15 carry the word MSB first. Slots 16..31 drive SDO = 0.
- R3: Mode 2 (long_frame_i = 1, half_sco_i = 1) uses 4-cycle slots, with SCO in its first level for 2 cycles and the other level for 2 cycles. It sends 16 data slots per 64-cycle frame.
- R4: Mode 3 (long_frame_i = 0, half_sco_i ignored) uses 2-cycle slots and 16 data slots per 32-cycle frame.
- R5: With launch_fall_i = 0, SCO is high in the first half of each slot, so SDO and FSO change on the SCO rising edge. With launch_fall_i = 1, SCO is low in the first half, so they change on the falling edge.
- R6: Outside the mode 1 square-wave case, FSO is high during slot 0 of each frame and low otherwise.
- R7: In mode 1 with fso_square_i = 1, FSO is low during slots 0..15 and high during slots 16..31.
- R8: The first accepted high level on sync_in_i after reset enters a hold state. There SCO = 0, FSO = 0 and SDO = 0 while sync_in_i stays high. At the first clock edge that sees sync_in_i low, a new frame starts at slot 0 with the holding word.
- R9: After one sync has been accepted, further sync_in_i pulses leave all outputs unchanged until the next reset.
- R10: In mode 1 with fso_square_i = 0, sync_in_i is ignored and does not use up the one-time sync.
- R11: sdo_oe_o is 1 exactly when drive_lvl_i equals slot_lvl_i.
- R12: A sample is captured on a clock edge where sample_vld_i = 1. A frame sends the holding value as it stood before the edge that starts the frame. A sample captured mid-frame, or on the frame-start edge, goes out in a later frame. Without a new sample the last word repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fabric clock, twice the master clock rate |
| rst_i | input | 1 | Synchronous reset, active high |
| sample_i | input | 16 | Sample word to send |
| sample_vld_i | input | 1 | Capture strobe for sample_i |
| long_frame_i | input | 1 | 1: 32-master-cycle word period; 0: 16 |
| half_sco_i | input | 1 | With long frame: serial clock at half the master rate |
| fso_square_i | input | 1 | Mode 1 frame marker as square wave |
| launch_fall_i | input | 1 | Launch data on the SCO falling edge |
| drive_lvl_i | input | 1 | Enable level compared with slot_lvl_i |
| slot_lvl_i | input | 1 | Transmitter identity level |
| sync_in_i | input | 1 | External frame sync, synchronous to clk_i |
| sco_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data value |
| sdo_oe_o | output | 1 | Serial data output enable |
| fso_o | output | 1 | Frame sync output |

## Verification
A wrong slot phase or bit index shows up as an SCO level or SDO bit that differs from the reference within one slot, which is two or four cycles. A wrong state shows as a misplaced FSO edge or a missing zero pad within one frame. A wrong holding or shift register gives a wrong SDO bit within the first slots of the next frame. A one-time sync flag that is wrongly set or cleared either skips the hold or restarts the frame on a later pulse. Either way SCO and FSO break on the very next cycle, and the reference model reports it.

// File: rtl/swm_pkg.sv
package swm_pkg;
    typedef enum logic [1:0] {
        ST_SYNC = 2'd0,
        ST_DATA = 2'd1,
        ST_PAD  = 2'd2
    } seq_state_t;
    localparam int unsigned PH_W = 2;
endpackage

// File: rtl/swm_seq.sv
module swm_seq
    import swm_pkg::*;
#(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned BIT_W  = $clog2(2 * WORD_W)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              long_i,
    input  logic              half_i,
    input  logic              square_i,
    input  logic              sync_i,
    output seq_state_t        state_o,
    output logic [PH_W-1:0]   ph_o,
    output logic [BIT_W-1:0]  bit_o,
    output logic              load_o,
    output logic              shift_o
);
    localparam logic [BIT_W-1:0] LAST_DATA = BIT_W'(WORD_W - 1);
    localparam logic [BIT_W-1:0] FIRST_PAD = BIT_W'(WORD_W);
    localparam logic [BIT_W-1:0] LAST_PAD  = BIT_W'(2 * WORD_W - 1);

    seq_state_t       state_q, state_n;
    logic [PH_W-1:0]  ph_q, ph_n;
    logic [BIT_W-1:0] bit_q, bit_n;
    logic             sync_done_q;
    logic             mode1, slow, sync_ok, sync_hit, slot_end;
    logic [PH_W-1:0]  slot_last;

    assign mode1     = long_i && !half_i;
    assign slow      = long_i && half_i;
    assign slot_last = slow ? PH_W'(3) : PH_W'(1);
    assign sync_ok   = !mode1 || square_i;
    assign sync_hit  = sync_i && !sync_done_q && sync_ok;
    assign slot_end  = (ph_q == slot_last);

    // next-state process
    always_comb begin
        state_n = state_q;
        ph_n    = ph_q;
        bit_n   = bit_q;
        load_o  = 1'b0;
        shift_o = 1'b0;
        if (sync_hit) begin
            state_n = ST_SYNC;
            ph_n    = '0;
            bit_n   = '0;
        end else begin
            unique case (state_q)
                ST_SYNC: begin
                    if (!sync_i) begin
                        state_n = ST_DATA;
                        ph_n    = '0;
                        bit_n   = '0;
                        load_o  = 1'b1;
                    end
                end
                ST_DATA: begin
                    if (slot_end) begin
                        ph_n = '0;
                        if (bit_q == LAST_DATA) begin
                            if (mode1) begin
                                state_n = ST_PAD;
                                bit_n   = FIRST_PAD;
                            end else begin
                                bit_n  = '0;
                                load_o = 1'b1;
                            end
                        end else begin
                            bit_n   = bit_q + 1'b1;
                            shift_o = 1'b1;
                        end
                    end else begin
                        ph_n = ph_q + 1'b1;
                    end
                end
                ST_PAD: begin
                    if (slot_end) begin
                        ph_n = '0;
                        if (bit_q == LAST_PAD) begin
                            state_n = ST_DATA;
                            bit_n   = '0;
                            load_o  = 1'b1;
                        end else begin
                            bit_n = bit_q + 1'b1;
                        end
                    end else begin
                        ph_n = ph_q + 1'b1;
                    end
                end
                default: begin
                    state_n = ST_DATA;
                    ph_n    = '0;
                    bit_n   = '0;
                end
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q     <= ST_DATA;
            ph_q        <= '0;
            bit_q       <= '0;
            sync_done_q <= 1'b0;
        end else begin
            state_q <= state_n;
            ph_q    <= ph_n;
            bit_q   <= bit_n;
            if (sync_hit) sync_done_q <= 1'b1;
        end
    end

    assign state_o = state_q;
    assign ph_o    = ph_q;
    assign bit_o   = bit_q;

    assert_sync_sticky_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        sync_done_q |=> sync_done_q);
    assert_sync_enter_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(sync_done_q) |-> state_q == ST_SYNC);
    assert_pad_mode1_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        state_q == ST_PAD |-> mode1);
    assert_short_range_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        !long_i |-> bit_q <= LAST_DATA);
    assert_slot_range_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        ph_q <= slot_last);
endmodule

// File: rtl/swm_shift.sv
module swm_shift #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [WORD_W-1:0] sample_i,
    input  logic              vld_i,
    input  logic              load_i,
    input  logic              shift_i,
    output logic              msb_o
);
    logic [WORD_W-1:0] hold_q, sh_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            hold_q <= '0;
            sh_q   <= '0;
        end else begin
            if (vld_i) hold_q <= sample_i;
            if (load_i) sh_q <= hold_q;
            else if (shift_i) sh_q <= {sh_q[WORD_W-2:0], 1'b0};
        end
    end

    assign msb_o = sh_q[WORD_W-1];

    assert_frame_load_R12: assert property (@(posedge clk_i) disable iff (rst_i)
        load_i |=> sh_q == $past(hold_q));
    assert_idle_keep_R12: assert property (@(posedge clk_i) disable iff (rst_i)
        (!load_i && !shift_i) |=> $stable(sh_q));
endmodule

// File: rtl/swm_pins.sv
module swm_pins
    import swm_pkg::*;
#(
    parameter int unsigned BIT_W = 5
) (
    input  seq_state_t       state_i,
    input  logic [PH_W-1:0]  ph_i,
    input  logic [BIT_W-1:0] bit_i,
    input  logic             msb_i,
    input  logic             long_i,
    input  logic             half_i,
    input  logic             square_i,
    input  logic             fall_i,
    input  logic             drive_i,
    input  logic             slot_i,
    output logic             sco_o,
    output logic             sdo_o,
    output logic             oe_o,
    output logic             fso_o
);
    logic first_half, sq_mode;

    // output process
    always_comb begin
        sq_mode    = long_i && !half_i && square_i;
        first_half = (long_i && half_i) ? !ph_i[1] : (ph_i == '0);
        oe_o       = (drive_i == slot_i);
        unique case (state_i)
            ST_SYNC: begin
                sco_o = 1'b0;
                sdo_o = 1'b0;
                fso_o = 1'b0;
            end
            ST_DATA: begin
                sco_o = first_half ^ fall_i;
                sdo_o = msb_i;
                fso_o = sq_mode ? 1'b0 : (bit_i == '0);
            end
            ST_PAD: begin
                sco_o = first_half ^ fall_i;
                sdo_o = 1'b0;
                fso_o = sq_mode;
            end
            default: begin
                sco_o = 1'b0;
                sdo_o = 1'b0;
                fso_o = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/serial_word_master.sv
module serial_word_master
    import swm_pkg::*;
#(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [WORD_W-1:0] sample_i,
    input  logic              sample_vld_i,
    input  logic              long_frame_i,
    input  logic              half_sco_i,
    input  logic              fso_square_i,
    input  logic              launch_fall_i,
    input  logic              drive_lvl_i,
    input  logic              slot_lvl_i,
    input  logic              sync_in_i,
    output logic              sco_o,
    output logic              sdo_o,
    output logic              sdo_oe_o,
    output logic              fso_o
);
    localparam int unsigned BIT_W = $clog2(2 * WORD_W);

    seq_state_t       state;
    logic [PH_W-1:0]  ph;
    logic [BIT_W-1:0] bitn;
    logic             load, shift, msb;

    swm_seq #(.WORD_W(WORD_W), .BIT_W(BIT_W)) u_seq (
        .clk_i(clk_i), .rst_i(rst_i),
        .long_i(long_frame_i), .half_i(half_sco_i), .square_i(fso_square_i),
        .sync_i(sync_in_i),
        .state_o(state), .ph_o(ph), .bit_o(bitn),
        .load_o(load), .shift_o(shift)
    );

    swm_shift #(.WORD_W(WORD_W)) u_shift (
        .clk_i(clk_i), .rst_i(rst_i),
        .sample_i(sample_i), .vld_i(sample_vld_i),
        .load_i(load), .shift_i(shift), .msb_o(msb)
    );

    swm_pins #(.BIT_W(BIT_W)) u_pins (
        .state_i(state), .ph_i(ph), .bit_i(bitn), .msb_i(msb),
        .long_i(long_frame_i), .half_i(half_sco_i), .square_i(fso_square_i),
        .fall_i(launch_fall_i), .drive_i(drive_lvl_i), .slot_i(slot_lvl_i),
        .sco_o(sco_o), .sdo_o(sdo_o), .oe_o(sdo_oe_o), .fso_o(fso_o)
    );

    assert_hold_quiet_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (state == ST_SYNC) |-> (!sco_o && !fso_o && !sdo_o));
endmodule

// File: tb/serial_word_master_test.sv
`timescale 1ns/1ps
module serial_word_master_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [15:0] sample = '0;
    logic vld = 1'b0, lng = 1'b1, half = 1'b0, sq = 1'b0, fall = 1'b0;
    logic drv = 1'b0, slt = 1'b0, fsi = 1'b0;
    logic sco, sdo, oe, fso;
    int total = 0, bad = 0;
    bit done = 1'b0;
    string tag_now = "R2";

    always #4 clk = ~clk;

    serial_word_master uut (
        .clk_i(clk), .rst_i(rst), .sample_i(sample), .sample_vld_i(vld),
        .long_frame_i(lng), .half_sco_i(half), .fso_square_i(sq),
        .launch_fall_i(fall), .drive_lvl_i(drv), .slot_lvl_i(slt),
        .sync_in_i(fsi), .sco_o(sco), .sdo_o(sdo), .sdo_oe_o(oe), .fso_o(fso)
    );

    task automatic chk(string req, string what, logic got, logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s got=%b exp=%b at %0t", req, what, got, exp, $time);
        end
    endtask

    // behavioural reference: position inside frame in clock cycles
    int m_pos = 0;
    bit m_synced = 0, m_holding = 0;
    logic [15:0] m_word = '0, m_hold = '0;

    always @(posedge clk) begin
        int flen, slen, slot, inph;
        bit ok, e_sco, e_sdo, e_fso;
        if (rst) begin
            m_pos = 0; m_word = '0; m_hold = '0; m_synced = 0; m_holding = 0;
        end else begin
            flen = lng ? 64 : 32;
            ok = !(lng && !half) || sq;
            if (fsi && !m_synced && ok) begin
                m_holding = 1; m_synced = 1; m_pos = 0;
            end else if (m_holding) begin
                if (!fsi) begin m_holding = 0; m_pos = 0; m_word = m_hold; end
            end else begin
                m_pos++;
                if (m_pos == flen) begin m_pos = 0; m_word = m_hold; end
            end
            if (vld) m_hold = sample;
        end
        #2;
        if (!rst) begin
            slen = (lng && half) ? 4 : 2;
            slot = m_pos / slen;
            inph = m_pos % slen;
            if (m_holding) begin
                e_sco = 0; e_sdo = 0; e_fso = 0;
            end else begin
                e_sco = (inph < slen / 2) ^ fall;
                e_sdo = (slot < 16) ? m_word[15 - slot] : 1'b0;
                e_fso = (lng && !half && sq) ? (slot >= 16) : (slot == 0);
            end
            chk(m_holding ? "R8" : "R5", "sco", sco, e_sco);
            chk(m_holding ? "R8" : tag_now, "sdo", sdo, e_sdo);
            chk(m_holding ? "R8" : ((lng && !half && sq) ? "R7" : "R6"), "fso", fso, e_fso);
            chk("R11", "oe", oe, drv == slt);
        end
    end

    task automatic setup(bit l, bit h, bit s, bit f, string t);
        @(negedge clk);
        rst = 1'b1; fsi = 1'b0; vld = 1'b0;
        lng = l; half = h; sq = s; fall = f; tag_now = t;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic feed(int n, int every, int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            vld = (i % every == 0);
            sample = 16'(seed * 977 + i * 4099) ^ 16'h5A3C;
        end
        @(negedge clk);
        vld = 1'b0;
    endtask

    task automatic fsi_pulse(int wait_n, int high_n);
        repeat (wait_n) @(negedge clk);
        fsi = 1'b1;
        repeat (high_n) @(negedge clk);
        fsi = 1'b0;
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1", "sco", sco, 1'b1);
        chk("R1", "sdo", sdo, 1'b0);
        chk("R1", "fso", fso, 1'b1);
        chk("R1", "oe", oe, 1'b1);
        rst = 1'b0;
        // R2 / R12: mode 1 pulse marker, sample mid-frame then often
        vld = 1'b1; sample = 16'hA5C3;
        @(negedge clk); vld = 1'b0;
        repeat (70) @(negedge clk);
        tag_now = "R12";
        vld = 1'b1; sample = 16'h3C96;
        @(negedge clk); vld = 1'b0;
        repeat (140) @(negedge clk);
        feed(130, 1, 3);
        repeat (70) @(negedge clk);
        // R7 / R5: mode 1 square marker, falling launch
        setup(1, 0, 1, 1, "R2");
        feed(200, 23, 7);
        // R3: mode 2
        setup(1, 1, 0, 0, "R3");
        feed(220, 31, 11);
        setup(1, 1, 0, 1, "R3");
        feed(140, 64, 13);
        // R4: mode 3, half select ignored
        setup(0, 0, 0, 1, "R4");
        feed(120, 17, 17);
        setup(0, 1, 1, 0, "R4");
        feed(120, 32, 19);
        // R10: mode 1 pulse marker ignores sync
        setup(1, 0, 0, 0, "R10");
        feed(10, 1, 23);
        fsi_pulse(13, 3);
        fsi_pulse(40, 1);
        repeat (80) @(negedge clk);
        // R8 / R9: mode 1 square marker
        setup(1, 0, 1, 0, "R8");
        feed(10, 1, 29);
        fsi_pulse(27, 5);
        repeat (40) @(negedge clk);
        tag_now = "R9";
        for (int k = 0; k < 3; k++) fsi_pulse(63, 1);
        feed(100, 20, 31);
        // R8 / R9: mode 3
        setup(0, 0, 0, 1, "R8");
        feed(5, 1, 37);
        fsi_pulse(11, 3);
        repeat (20) @(negedge clk);
        tag_now = "R9";
        for (int k = 0; k < 3; k++) fsi_pulse(31, 2);
        repeat (40) @(negedge clk);
        // R8: mode 2 sync
        setup(1, 1, 0, 0, "R8");
        feed(5, 1, 41);
        fsi_pulse(9, 4);
        repeat (80) @(negedge clk);
        // R11: enable levels
        setup(0, 0, 0, 0, "R11");
        for (int k = 0; k < 16; k++) begin
            @(negedge clk);
            drv = k[0]; slt = k[1];
        end
        drv = 1'b1; slt = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11", "oe off", oe, 1'b0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule